// File: doc/BRIEF.md
# Parallel NOR Flash Bus Front End

This block is the host-facing side of a small parallel NOR flash memory. It samples the active-low chip, write and output strobes on a fast system clock and passes each strobe through a two-flop synchronizer. The chip and write strobes then go through a stable-sample glitch filter. Each bus cycle is sorted into read, write, output disable, standby or automatic standby.

Write cycles are captured for a downstream command interpreter. The address is taken when the later of the chip and write strobes falls. The data is taken when the first of them rises. The captured pair is then handed over as a one-cycle pulse.

Read cycles drive the data bus, with a per-bit output enable, from a cell-array read port or from two identifier registers. The identifier registers are selected by a high-voltage flag on address bit 9. A byte/word select input narrows the bus to eight bits and turns the top data pin into the lowest address bit.

Top module: `nor_bus_front`

## Requirements
- R1: `op` reports the bus state with code 0 = standby (chip strobe high), 2 = write (chip and write strobes low), 4 = automatic standby, 1 = read (output strobe low), 3 = output disable. The checks apply in that priority order.
- R2: With chip and output strobes low and the write strobe high, the block drives `dq_out` with `arr_rdata`, and `dq_oe` is all ones in word mode. `arr_addr` is `{addr, lsb}`, where lsb is `dq_in[15]` in byte mode and 0 in word mode.
- R3: While the output strobe is high, or the chip strobe is high, `dq_oe` is zero.
- R4: A write latches `{addr, lsb}` in the cycle when the later of the two strobes is seen low. Later address changes during the cycle do not alter it.
- R5: A write latches data when the first of the two strobes is seen high. The block then raises `wr_valid` for exactly one cycle, carrying `wr_addr`/`wr_data`. Data changes after that point do not alter it.
- R6: If the output strobe goes low while a write is in progress, the block pulses `proto_err` once and no `wr_valid` follows for that cycle.
- R7: A chip or write strobe level is accepted only after FILT consecutive synchronized samples. A write-strobe pulse shorter than that produces no write.
- R8: Identifier read: `hv_a9` set, `addr[1]` low and every address bit other than bits 0, 1 and 9 low. In that case a read returns 0x0020 when `addr[0]` is 0, and 0x0057 (BOTTOM_BOOT=1) or 0x0051 (BOTTOM_BOOT=0) when `addr[0]` is 1.
- R9: In byte mode (`byte_n` low), `dq_oe` is 0x00FF and `dq_out[15:8]` is zero. Identifiers read as 8-bit codes, and write data is `dq_in[7:0]` zero-extended.
- R10: `active` is high whenever `busy` is high. `op` becomes 4 only when `busy` is low, the chip strobe is low and the write strobe is high, and neither the address nor any strobe has changed for IDLE_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| byte_n | input | 1 | 1 = 16-bit word mode, 0 = byte mode |
| addr | input | AW | Address bus |
| hv_a9 | input | 1 | High-voltage flag on address bit 9 |
| busy | input | 1 | Program/erase in progress |
| dq_in | input | 16 | Data bus input side |
| dq_out | output | 16 | Data bus output side |
| dq_oe | output | 16 | Per-bit output enable for the data bus |
| arr_addr | output | AW+1 | Cell array read address |
| arr_rdata | input | 16 | Cell array read data |
| wr_valid | output | 1 | One-cycle pulse for a latched write |
| wr_addr | output | AW+1 | Latched write address |
| wr_data | output | 16 | Latched write data |
| proto_err | output | 1 | Output strobe low during a write |
| op | output | 3 | Decoded bus operation |
| active | output | 1 | Active supply current mode |

## Verification
The bench builds the block with FILT=3 and IDLE_CYC=16. A two-sample write-strobe pulse therefore falls just short of the filter and must be dropped. The automatic standby timeout expires within a few dozen cycles, so the entry into low-power read and its cancellation by `busy` can be observed. BOTTOM_BOOT keeps its default, so the device identifier is checked against 0x57.

// File: rtl/nor_bus_front.sv
module nor_bus_front #(
  parameter int AW          = 17,
  parameter int FILT        = 3,
  parameter int IDLE_CYC    = 64,
  parameter bit BOTTOM_BOOT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic          byte_n,
  input  logic [AW-1:0] addr,
  input  logic          hv_a9,
  input  logic          busy,
  input  logic [15:0]   dq_in,
  output logic [15:0]   dq_out,
  output logic [15:0]   dq_oe,
  output logic [AW:0]   arr_addr,
  input  logic [15:0]   arr_rdata,
  output logic          wr_valid,
  output logic [AW:0]   wr_addr,
  output logic [15:0]   wr_data,
  output logic          proto_err,
  output logic [2:0]    op,
  output logic          active
);
  localparam int CW = $clog2(FILT + 1);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [AW-1:0] ID_FREE = AW'(32'h203);
  localparam logic [2:0] OP_STBY = 3'd0, OP_READ = 3'd1, OP_WRITE = 3'd2,
                         OP_ODIS = 3'd3, OP_AUTO = 3'd4;

  logic [1:0] ce_sy, we_sy, oe_sy;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ce_sy <= 2'b11; we_sy <= 2'b11; oe_sy <= 2'b11;
    end else begin
      ce_sy <= {ce_sy[0], ce_n};
      we_sy <= {we_sy[0], we_n};
      oe_sy <= {oe_sy[0], oe_n};
    end

  logic          raw [2];
  logic          flt [2];
  logic [CW-1:0] fcnt [2];
  assign raw[0] = ce_sy[1];
  assign raw[1] = we_sy[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        flt[i]  <= 1'b1;
        fcnt[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        if (raw[i] == flt[i]) fcnt[i] <= '0;
        else if (fcnt[i] == CW'(FILT - 1)) begin
          flt[i]  <= raw[i];
          fcnt[i] <= '0;
        end else fcnt[i] <= fcnt[i] + 1'b1;
      end
    end

  logic ce_f, we_f, oe_s;
  assign ce_f = flt[0];
  assign we_f = flt[1];
  assign oe_s = oe_sy[1];

  logic [AW:0] cur_addr;
  assign cur_addr = {addr, byte_n ? 1'b0 : dq_in[15]};
  assign arr_addr = cur_addr;

  logic wr_act, wr_act_q, pend;
  assign wr_act = !ce_f && !we_f;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_act_q <= 1'b0; pend <= 1'b0; wr_valid <= 1'b0; proto_err <= 1'b0;
      wr_addr <= '0; wr_data <= '0;
    end else begin
      wr_act_q  <= wr_act;
      wr_valid  <= 1'b0;
      proto_err <= 1'b0;
      if (wr_act && !wr_act_q) begin
        pend    <= 1'b1;
        wr_addr <= cur_addr;
      end else if (wr_act && pend && !oe_s) begin
        pend      <= 1'b0;
        proto_err <= 1'b1;
      end else if (!wr_act && wr_act_q && pend) begin
        pend     <= 1'b0;
        wr_valid <= 1'b1;
        wr_data  <= byte_n ? dq_in : {8'h00, dq_in[7:0]};
      end
    end

  logic        rd, id_sel;
  logic [7:0]  id_code;
  logic [15:0] word_val;
  assign rd       = !ce_f && !oe_s && we_f;
  assign id_sel   = hv_a9 && !addr[1] && ((addr & ~ID_FREE) == '0);
  assign id_code  = addr[0] ? (BOTTOM_BOOT ? 8'h57 : 8'h51) : 8'h20;
  assign word_val = id_sel ? {8'h00, id_code} : arr_rdata;
  assign dq_out   = !rd ? 16'h0000 : byte_n ? word_val : {8'h00, word_val[7:0]};
  assign dq_oe    = !rd ? 16'h0000 : byte_n ? 16'hFFFF : 16'h00FF;

  logic [AW+2:0] snap;
  logic [IW-1:0] idle_cnt;
  logic          idle_done;
  assign idle_done = idle_cnt == IW'(IDLE_CYC);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      snap <= '0; idle_cnt <= '0;
    end else begin
      snap <= {addr, ce_f, we_f, oe_s};
      if (busy || snap != {addr, ce_f, we_f, oe_s}) idle_cnt <= '0;
      else if (!idle_done) idle_cnt <= idle_cnt + 1'b1;
    end

  always_comb
    if (ce_f)                 op = OP_STBY;
    else if (!we_f)           op = OP_WRITE;
    else if (idle_done && !busy) op = OP_AUTO;
    else if (!oe_s)           op = OP_READ;
    else                      op = OP_ODIS;

  assign active = busy || !(op == OP_STBY || op == OP_AUTO);

  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R6
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> !wr_valid);
  // R3
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_STBY || op == OP_ODIS || op == OP_WRITE) |-> dq_oe == 16'h0000);
  // R10
  busy_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> active);
  // R9
  byte_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_n |-> dq_oe[15:8] == 8'h00);
endmodule

// File: tb/nor_bus_front_tb_top.sv
module nor_bus_front_tb_top;
  localparam int AW = 17;
  logic clk = 0, rst_n = 0;
  logic ce_n = 1, we_n = 1, oe_n = 1, byte_n = 1, hv_a9 = 0, busy = 0;
  logic [AW-1:0] addr = '0;
  logic [15:0] dq_in = '0;
  logic [15:0] dq_out, dq_oe, arr_rdata, wr_data;
  logic [AW:0] arr_addr, wr_addr;
  logic wr_valid, proto_err, active;
  logic [2:0] op;

  int n_chk = 0, n_fail = 0, n_wv = 0;
  bit err_seen = 0, done = 0;
  logic [AW+16:0] exp_q [$];

  always #5 clk = ~clk;
  assign arr_rdata = arr_addr[15:0] ^ 16'hA5C3;

  nor_bus_front #(.AW(AW), .FILT(3), .IDLE_CYC(16), .BOTTOM_BOOT(1'b1)) dut_i (
    .clk, .rst_n, .ce_n, .we_n, .oe_n, .byte_n, .addr, .hv_a9, .busy, .dq_in,
    .dq_out, .dq_oe, .arr_addr, .arr_rdata, .wr_valid, .wr_addr, .wr_data,
    .proto_err, .op, .active);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (proto_err) err_seen = 1;
    if (wr_valid) begin
      n_wv++;
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R5 unexpected write actual=%h/%h expected=none", wr_addr, wr_data);
      end else begin
        logic [AW+16:0] e;
        e = exp_q.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          n_fail++;
          $display("FAIL R4/R5 write actual=%h expected=%h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  task automatic do_write(logic [AW-1:0] a, logic [15:0] d);
    logic am1;
    am1 = byte_n ? 1'b0 : d[15];
    exp_q.push_back({a, am1, byte_n ? d : {8'h00, d[7:0]}});
    addr = a; dq_in = d;
    ce_n = 0; settle(8);
    we_n = 0; settle(8);
    we_n = 1; settle(8);
    ce_n = 1; settle(8);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int wv0;
    logic [15:0] e;
    settle(3);
    check("R1 reset op", 32'(op), 0);
    check("R3 reset dq_oe", 32'(dq_oe), 0);
    rst_n = 1;
    settle(4);

    // R4 R5 word write
    do_write(17'h0AAA5, 16'h1234);
    do_write(17'h05555, 16'hBEEF);
    // R9 byte write, dq_in[15] as lsb
    byte_n = 0;
    do_write(17'h00155, 16'h80A0);
    byte_n = 1;
    settle(4);
    check("R5 writes delivered", 32'(n_wv), 3);

    // R4 R5 ordering: addr at later fall, data at first rise
    exp_q.push_back({17'h00222, 1'b0, 16'h4444});
    addr = 17'h00111; ce_n = 0; settle(8);
    addr = 17'h00222; settle(2);
    we_n = 0; settle(8);
    addr = 17'h00333; dq_in = 16'h4444; settle(2);
    we_n = 1; settle(8);
    dq_in = 16'h5555; settle(2);
    ce_n = 1; settle(8);
    check("R4 R5 ordering delivered", 32'(n_wv), 4);

    // R7 glitch on write strobe
    wv0 = n_wv;
    addr = 17'h00010; ce_n = 0; settle(8);
    we_n = 0; settle(2); we_n = 1; settle(10);
    check("R7 glitch no write", 32'(n_wv - wv0), 0);
    check("R7 op not write", 32'(op), 3);
    ce_n = 1; settle(8);

    // R6 output strobe low during write
    wv0 = n_wv;
    ce_n = 0; settle(8); we_n = 0; settle(8);
    oe_n = 0; settle(8); oe_n = 1; settle(2);
    we_n = 1; settle(8); ce_n = 1; settle(8);
    check("R6 proto_err seen", 32'(err_seen), 1);
    check("R6 no write", 32'(n_wv - wv0), 0);

    // R2 word read
    addr = 17'h00123; ce_n = 0; oe_n = 0; settle(8);
    check("R2 dq_oe word", 32'(dq_oe), 32'hFFFF);
    e = {addr, 1'b0} ^ 16'hA5C3;
    check("R2 read data", 32'(dq_out), 32'(e));
    check("R1 op read", 32'(op), 1);

    // R9 byte read
    byte_n = 0; dq_in = 16'h8000; addr = 17'h00005; settle(8);
    e = 16'h000B ^ 16'hA5C3;
    check("R9 dq_oe byte", 32'(dq_oe), 32'h00FF);
    check("R9 byte data", 32'(dq_out), 32'(e[7:0]));

    // R8 identifier reads
    byte_n = 1; hv_a9 = 1; addr = 17'h00000; settle(8);
    check("R8 manufacturer", 32'(dq_out), 32'h0020);
    addr = 17'h00001; settle(8);
    check("R8 device", 32'(dq_out), 32'h0057);
    addr = 17'h00201; settle(8);
    check("R8 device with A9 bit", 32'(dq_out), 32'h0057);
    byte_n = 0; settle(8);
    check("R9 byte device", 32'(dq_out), 32'h0057);
    check("R9 byte id oe", 32'(dq_oe), 32'h00FF);
    byte_n = 1; addr = 17'h00011; settle(8);
    e = {addr, 1'b0} ^ 16'hA5C3;
    check("R8 non-id address reads array", 32'(dq_out), 32'(e));
    hv_a9 = 0;

    // R10 automatic standby
    settle(30);
    check("R10 op auto", 32'(op), 4);
    check("R10 inactive", 32'(active), 0);
    busy = 1; settle(2);
    check("R10 busy cancels auto", 32'(op), 1);
    check("R10 busy active", 32'(active), 1);
    busy = 0;

    // R3 R1 output disable and standby
    oe_n = 1; settle(8);
    check("R3 odis dq_oe", 32'(dq_oe), 0);
    check("R1 op odis", 32'(op), 3);
    ce_n = 1; settle(8);
    check("R1 op standby", 32'(op), 0);
    check("R3 standby dq_oe", 32'(dq_oe), 0);
    check("R10 standby inactive", 32'(active), 0);
    busy = 1; settle(2);
    check("R10 busy in standby", 32'(active), 1);
    busy = 0; settle(2);

    check("R5 scoreboard empty", 32'(exp_q.size()), 0);
    finish_run();
  end
endmodule